// File: doc/BRIEF.md
# Two-Wire Bus Frame Guard

This block observes the clock (SCL) and data (SDA) lines of a two-wire serial bus and follows each frame of nine bit slots: eight data or address bits and one acknowledge bit. A START or STOP condition is legal only in the gap between frames. If one appears inside an address bit, a data bit or the acknowledge bit, the block latches a bus error. It then raises its interrupt flag and switches its status code from the idle value to the error value.

The host sees three things: an 8-bit status code, the interrupt flag, and a small control word. A bus error puts the interface into an error state that ordinary flag clearing cannot leave. To recover, the host must clear the flag and request a stop in the same write. The block then goes back to the idle, not-addressed slave state, drops the stop request and releases its hold on SCL. No STOP condition is ever requested on the bus during recovery.

Top module: `twi_frame_guard`

## Requirements
- R1: After reset, status_o reads 0xF8, irq_o is 0, slave_idle_o is 1, bus_busy_o is 0, frame_pos_o is 0 and ctrl_o is 0.
- R2: A START is an SDA fall while SCL stays high. A START seen while the bus is idle sets bus_busy_o and sets frame_pos_o to 0 without raising irq_o.
- R3: frame_pos_o counts bit slots completed in the current frame, where a slot completes on an SCL fall that follows an SCL rise. The first SCL fall after a START is not counted. The count wraps from FRAME_BITS-1 to 0, and it stays at 0 while the bus is idle.
- R4: A START or STOP seen while frame_pos_o is 0, or while the bus is idle, is legal and leaves irq_o at 0. A repeated START keeps bus_busy_o at 1, and a STOP (an SDA rise while SCL stays high) clears it.
- R5: A START or STOP seen while the bus is busy and frame_pos_o is nonzero is a bus error. It sets irq_o, makes status_o read 0x00, drops slave_idle_o and sets frame_pos_o to 0. bus_busy_o becomes 1 if the offending condition was a START and 0 if it was a STOP.
- R6: scl_low_o, the request to stretch SCL, is high exactly while irq_o is set.
- R7: ctrl_o bit positions are [0] interrupt flag, [1] acknowledge enable, [2] start request and [3] stop request, and host_wdata uses the same positions. Writing 0 to bit 0 never clears irq_o. Outside the error state, writing 1 to bit 0 clears irq_o. In the error state, writing 1 to bit 0 without also writing 1 to bit 3 leaves irq_o and status_o unchanged.
- R8: A write in the error state with host_wdata bits 0 and 3 both at 1 performs recovery. After it, irq_o is 0, status_o reads 0xF8, slave_idle_o is 1, scl_low_o is 0, ctrl_o bit 3 is 0, bits 1 and 2 take the written values, and stop_gen_o never pulses.
- R9: Outside the error state, with irq_o clear, writing 1 to bit 3 stores the stop request, and stop_gen_o is high while that request is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line level, asynchronous |
| sda_i | input | 1 | Raw SDA line level, asynchronous |
| host_we | input | 1 | Host write strobe for the control word |
| host_wdata | input | 4 | Control write data: [0] flag clear, [1] ack enable, [2] start request, [3] stop request |
| status_o | output | 8 | Status code: 0xF8 when no information is available, 0x00 on a bus error |
| irq_o | output | 1 | Interrupt flag |
| ctrl_o | output | 4 | Control word readback, same bit layout as host_wdata |
| slave_idle_o | output | 1 | High in the not-addressed slave state, low in the error state |
| bus_busy_o | output | 1 | A frame is in progress (START seen, no STOP yet) |
| frame_pos_o | output | $clog2(FRAME_BITS) | Bit slots completed in the current frame |
| scl_low_o | output | 1 | Request to hold SCL low while the flag is pending |
| stop_gen_o | output | 1 | Request to the master engine to drive a STOP |

## Verification
The bench aims at the three places where an illegal condition can sit: inside the address byte, in the middle of a data byte, and in the high phase of the acknowledge slot. A counter that counted the acknowledge rise early, or that counted the fall right after a START, would either miss the acknowledge-slot error or flag a legal repeated START. The recovery write is tested against two near misses: a flag clear without the stop bit, and a stop bit without the flag clear. A design that accepted either would leave the error state too early. The bench also watches stop_gen_o through every recovery, so a design that turned the stop request into a real STOP would be caught. A stray STOP on an idle bus, and a START followed straight away by a STOP, are both checked as legal.

// File: rtl/twi_frame_guard.sv
module twi_frame_guard #(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          scl_i,
  input  logic                          sda_i,
  input  logic                          host_we,
  input  logic [3:0]                    host_wdata,
  output logic [7:0]                    status_o,
  output logic                          irq_o,
  output logic [3:0]                    ctrl_o,
  output logic                          slave_idle_o,
  output logic                          bus_busy_o,
  output logic [$clog2(FRAME_BITS)-1:0] frame_pos_o,
  output logic                          scl_low_o,
  output logic                          stop_gen_o
);

  localparam int PW = $clog2(FRAME_BITS);
  localparam logic [PW-1:0] LAST_POS = PW'(FRAME_BITS - 1);
  localparam logic [7:0] CODE_NONE   = 8'hF8;
  localparam logic [7:0] CODE_BUSERR = 8'h00;

  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic scl_d, sda_d;
  wire  scl_s = scl_sr[SYNC_STAGES-1];
  wire  sda_s = sda_sr[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end

  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire cond_start = scl_s & scl_d & sda_d & ~sda_s;
  wire cond_stop  = scl_s & scl_d & ~sda_d & sda_s;

  logic          busy, rose_seen;
  logic [PW-1:0] pos;

  wire illegal = (cond_start | cond_stop) & busy & (pos != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy      <= 1'b0;
      pos       <= '0;
      rose_seen <= 1'b0;
    end else if (cond_start | cond_stop) begin
      busy      <= cond_start;
      pos       <= '0;
      rose_seen <= 1'b0;
    end else begin
      if (scl_rise) rose_seen <= 1'b1;
      if (scl_fall) begin
        rose_seen <= 1'b0;
        if (busy && rose_seen) pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
      end
    end

  logic err_mode, flag, ack_en, sta_req, sto_req;

  wire recover   = host_we & host_wdata[0] & host_wdata[3] & err_mode;
  wire flag_clr  = host_we & host_wdata[0] & (~err_mode | host_wdata[3]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      err_mode <= 1'b0;
      flag     <= 1'b0;
    end else if (illegal) begin
      err_mode <= 1'b1;
      flag     <= 1'b1;
    end else begin
      if (recover)  err_mode <= 1'b0;
      if (flag_clr) flag     <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ack_en  <= 1'b0;
      sta_req <= 1'b0;
      sto_req <= 1'b0;
    end else if (host_we) begin
      ack_en  <= host_wdata[1];
      sta_req <= host_wdata[2];
      sto_req <= recover ? 1'b0 : host_wdata[3];
    end

  assign status_o     = flag ? CODE_BUSERR : CODE_NONE;
  assign irq_o        = flag;
  assign ctrl_o       = {sto_req, sta_req, ack_en, flag};
  assign slave_idle_o = ~err_mode;
  assign bus_busy_o   = busy;
  assign frame_pos_o  = pos;
  assign scl_low_o    = flag;
  assign stop_gen_o   = sto_req & ~flag & ~err_mode;

endmodule

// File: rtl/twi_frame_guard_chk.sv
module twi_frame_guard_chk #(
  parameter int FRAME_BITS = 9
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          host_we,
  input logic [3:0]                    host_wdata,
  input logic [7:0]                    status_o,
  input logic                          irq_o,
  input logic [3:0]                    ctrl_o,
  input logic                          slave_idle_o,
  input logic                          bus_busy_o,
  input logic [$clog2(FRAME_BITS)-1:0] frame_pos_o,
  input logic                          scl_low_o,
  input logic                          stop_gen_o
);

  // R1
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 8'hF8) || (status_o == 8'h00));

  // R3
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pos_o <= ($clog2(FRAME_BITS))'(FRAME_BITS - 1));

  // R3
  idle_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy_o |-> frame_pos_o == '0);

  // R5
  err_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> !slave_idle_o && status_o == 8'h00);

  // R6
  stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_low_o == irq_o);

  // R7
  fell_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(host_we && host_wdata[0]));

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !slave_idle_o && host_we && host_wdata[0] && !host_wdata[3] |=> irq_o);

  // R8
  recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !slave_idle_o && host_we && host_wdata[0] && host_wdata[3]
      |=> !ctrl_o[3] && !stop_gen_o);

  // R9
  stop_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_gen_o |-> !irq_o && slave_idle_o && ctrl_o[3]);

endmodule

bind twi_frame_guard twi_frame_guard_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wdata(host_wdata),
  .status_o(status_o), .irq_o(irq_o), .ctrl_o(ctrl_o),
  .slave_idle_o(slave_idle_o), .bus_busy_o(bus_busy_o),
  .frame_pos_o(frame_pos_o), .scl_low_o(scl_low_o), .stop_gen_o(stop_gen_o)
);

// File: tb/twi_frame_guard_test.sv
module twi_frame_guard_test;
  logic clk = 0, rst_n = 0, scl = 1, sda = 1, we = 0;
  logic [3:0] wd = 0;
  logic [7:0] status;
  logic irq, sidle, busy, scl_low, sgen;
  logic [3:0] ctrl, pos;
  int tests = 0, fails = 0, sg_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  twi_frame_guard uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .host_we(we), .host_wdata(wd), .status_o(status), .irq_o(irq),
    .ctrl_o(ctrl), .slave_idle_o(sidle), .bus_busy_o(busy),
    .frame_pos_o(pos), .scl_low_o(scl_low), .stop_gen_o(sgen)
  );

  always @(posedge clk) if (sgen) sg_cnt++;

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_scl(logic v); scl = v; idle(4); endtask
  task automatic set_sda(logic v); sda = v; idle(4); endtask

  task automatic bus_start();
    set_sda(1); set_scl(1); set_sda(0); set_scl(0);
  endtask

  task automatic bus_stop();
    set_scl(0); set_sda(0); set_scl(1); set_sda(1);
  endtask

  task automatic send_bit(logic b);
    set_scl(0); set_sda(b); set_scl(1); set_scl(0);
  endtask

  task automatic host_write(logic [3:0] d);
    we = 1; wd = d; idle(1); we = 0; wd = 0; idle(1);
  endtask

  task automatic recover();
    host_write(4'b1001);
  endtask

  task automatic t_reset();
    chk("R1", "status", status, 8'hF8);
    chk("R1", "irq", irq, 0);
    chk("R1", "slave_idle", sidle, 1);
    chk("R1", "busy", busy, 0);
    chk("R1", "pos", pos, 0);
    chk("R1", "ctrl", ctrl, 0);
  endtask

  task automatic t_legal_frame();
    set_scl(1); set_sda(0); set_sda(1);
    chk("R4", "stray stop irq", irq, 0);
    chk("R4", "stray stop busy", busy, 0);
    bus_start();
    chk("R2", "busy after start", busy, 1);
    chk("R2", "pos after start", pos, 0);
    chk("R2", "irq after start", irq, 0);
    for (int i = 0; i < 3; i++) send_bit(i[0]);
    chk("R3", "pos after 3 bits", pos, 3);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    chk("R3", "pos wraps after 9", pos, 0);
    set_sda(1); set_scl(1); set_sda(0);
    chk("R4", "repeated start busy", busy, 1);
    chk("R4", "repeated start irq", irq, 0);
    set_scl(0);
    chk("R3", "fall after start not counted", pos, 0);
    bus_stop();
    chk("R4", "stop at frame gap busy", busy, 0);
    chk("R4", "stop at frame gap irq", irq, 0);
    chk("R4", "status idle", status, 8'hF8);
  endtask

  task automatic t_err_data();
    sg_cnt = 0;
    bus_start();
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    set_sda(0); set_scl(1); set_sda(1);
    chk("R5", "irq on stop in byte", irq, 1);
    chk("R5", "status bus error", status, 8'h00);
    chk("R5", "slave_idle dropped", sidle, 0);
    chk("R5", "busy after stop error", busy, 0);
    chk("R5", "pos after error", pos, 0);
    chk("R6", "scl held", scl_low, 1);
    host_write(4'b0001);
    chk("R7", "flag clear w/o stop ignored", irq, 1);
    chk("R7", "status kept", status, 8'h00);
    host_write(4'b1000);
    chk("R7", "write 0 to flag ignored", irq, 1);
    host_write(4'b1011);
    chk("R8", "irq after recovery", irq, 0);
    chk("R8", "status after recovery", status, 8'hF8);
    chk("R8", "slave_idle after recovery", sidle, 1);
    chk("R8", "ctrl after recovery", ctrl, 4'b0010);
    chk("R6", "scl released", scl_low, 0);
    chk("R8", "no stop generated", sg_cnt, 0);
    host_write(4'b0000);
  endtask

  task automatic t_err_ack();
    sg_cnt = 0;
    bus_start();
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    chk("R3", "pos at ack slot", pos, 8);
    set_scl(0); set_sda(1); set_scl(1); set_sda(0);
    chk("R5", "irq on start in ack", irq, 1);
    chk("R5", "busy after start error", busy, 1);
    chk("R5", "slave_idle dropped ack", sidle, 0);
    recover();
    chk("R8", "recovered from ack error", irq, 0);
    chk("R8", "stop req cleared", ctrl[3], 0);
    chk("R8", "no stop generated ack", sg_cnt, 0);
    set_scl(0); set_sda(0); set_scl(1); set_sda(1);
  endtask

  task automatic t_err_addr();
    bus_start();
    send_bit(1'b1);
    set_scl(0); set_sda(1); set_scl(1); set_sda(0);
    chk("R5", "irq on start in address", irq, 1);
    recover();
    bus_stop();
  endtask

  task automatic t_stop_req();
    sg_cnt = 0;
    host_write(4'b1000);
    chk("R9", "stop req stored", ctrl[3], 1);
    chk("R9", "stop_gen high", sgen, 1);
    host_write(4'b0001);
    chk("R9", "stop_gen drops", sgen, 0);
    chk("R7", "flag clear when idle", irq, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    t_reset();
    t_legal_frame();
    t_err_data();
    t_err_ack();
    t_err_addr();
    t_stop_req();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog all requirements: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule